// File: doc/BRIEF.md
# SPI Master with Threshold FIFOs

This block is a full-duplex SPI bus master. A host pushes 32-bit words into a transmit FIFO and pops 32-bit words from a receive FIFO, one entry per access. The block shifts each transmit word out on MOSI, most significant bit first. For each word it shifts out, it captures one receive word from MISO. The frame length can be set from 4 to 32 bits. Transmit bits above the frame are dropped, and receive words come back zero-extended. The timing is SPI mode 0: SCLK idles low, both sides sample on the rising edge, and data changes while SCLK is low. The SCLK period is an even multiple of the system clock.

One chip select line, picked by `cs_sel`, stays low for as long as the transmit FIFO has work. A burst of back-to-back words therefore runs under a single select. The block has three sticky status bits: transmit FIFO low, receive FIFO high, and receive overrun. A level-sensitive interrupt is the OR of the enabled status bits. Two DMA handshake lines follow the live threshold conditions.

The serial engine is a five-state machine:
- `ST_IDLE`: all selects high, SCLK low, MOSI low. If the transmit FIFO is not empty, it pops a word and goes to `ST_LEAD`.
- `ST_LEAD`: the select goes low and the first bit is on MOSI. After a half period it goes to `ST_HIGH`, sampling MISO on the way.
- `ST_HIGH`: SCLK is high. After a half period it goes to `ST_LOW`, or to `ST_TAIL` on the last bit, when the receive word is pushed.
- `ST_LOW`: the next bit is on MOSI. After a half period it goes to `ST_HIGH`, sampling MISO on the way.
- `ST_TAIL`: the select is held for a half period. It then goes to `ST_LEAD` with a fresh pop if words remain, or to `ST_IDLE`.

Top module: `spi_fifo_master`

## Requirements
- R1: SCLK is low outside transfers. Each bit lasts one period of 2*H system clocks, where H is `half_div`, and a `half_div` of 0 counts as 1.
- R2: Every transmitted frame produces exactly one receive FIFO entry.
- R3: A `host_wr` pulse adds one entry and a `host_rd` pulse removes the head entry. A write to a full transmit FIFO and a read of an empty receive FIFO have no effect.
- R4: MOSI carries the low F bits of each word, most significant first, where F is `frame_bits`. Values below 4 act as 4 and values above 32 act as 32.
- R5: MISO is sampled at each SCLK rising edge into the low F bits, first bit most significant. Bits above F read as zero, and MOSI never changes while SCLK is high.
- R6: Only `cs_n[cs_sel]` goes low during a burst, where `cs_sel` is latched when the burst starts. It stays low across queued words.
- R7: `cs_n[cs_sel]` falls H clocks before the first SCLK rise. It rises H clocks after the last SCLK fall.
- R8: Status bit 0 is set while the transmit level is at or below `tx_thresh`. Status bit 1 is set while the receive level is nonzero and at or above `rx_thresh`. A set bit stays set until a `status_clr` pulse arrives on that bit while its condition is absent.
- R9: `irq` is high whenever any status bit is set together with its `irq_en` bit.
- R10: `dma_tx_req` equals `dma_en[0]` AND the live transmit condition. `dma_rx_req` equals `dma_en[1]` AND the live receive condition.
- R11: A frame that ends while the receive FIFO is full is dropped and sets sticky status bit 2.
- R12: During and right after reset, MOSI is low, all selects are high, SCLK is low, both FIFOs are empty and the status bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Push `host_wdata` into the transmit FIFO |
| host_wdata | input | 32 | Transmit word |
| host_rd | input | 1 | Pop the receive FIFO head |
| host_rdata | output | 32 | Receive FIFO head |
| tx_full | output | 1 | Transmit FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| tx_level | output | TXC | Transmit FIFO occupancy |
| rx_level | output | RXC | Receive FIFO occupancy |
| frame_bits | input | 6 | Frame length in bits |
| half_div | input | DIV_W | SCLK half period in clocks |
| cs_sel | input | CSW | Chip select index |
| tx_thresh | input | TXC | Transmit low threshold |
| rx_thresh | input | RXC | Receive high threshold |
| irq_en | input | 3 | Interrupt enable per status bit |
| dma_en | input | 2 | DMA request enables (0 transmit, 1 receive) |
| status_clr | input | 3 | Clear pulse per status bit |
| status | output | 3 | Sticky status: 0 transmit low, 1 receive high, 2 overrun |
| irq | output | 1 | Level interrupt, active high |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |

## Verification
Some properties are checked on every cycle:
- SCLK stays low whenever no select is asserted.
- MOSI holds still through each high phase.
- A receive push happens only at the end of a high phase.
- FIFO occupancy never passes its depth, and a write to a full FIFO leaves it full.
- A status bit never drops without its clear, and an overrun always latches.
- Selects are high and MOSI is low just after reset.

Other behaviour only the bench scenarios can show:
- The bit order and values on the wire, and the receive data under inverted loopback.
- The exact lead, tail and period counts, and that one select covers a queued burst.
- The threshold crossings that drive the interrupt and DMA lines.
- Which words survive an overrun.

// File: rtl/spi_pkg.sv
package spi_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } spi_state_e;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  pdata,
    input  logic          pop,
    output logic [W-1:0]  qdata,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign do_push = push && (count != FULLV);
    assign do_pop  = pop && (count != '0);
    assign qdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= pdata;
    end

    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= FULLV);
    a_r3_full_push_ignored: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && count == FULLV) |=> (count == FULLV));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_pkg::*;
#(
    parameter int NCS   = 4,
    parameter int DIV_W = 8,
    localparam int CSW  = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_pop,
    input  logic [5:0]        fsz,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [CSW-1:0]    cs_sel,
    input  logic              miso,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi,
    output logic [NCS-1:0]    cs_n
);
    spi_state_e        st, st_nx;
    logic [DIV_W-1:0]  hc, half_m1;
    logic [5:0]        bits_left;
    logic [WORD_W-1:0] tsh, rsh;
    logic [CSW-1:0]    cs_q;
    logic              tick;

    assign half_m1 = (half_div == '0) ? '0 : half_div - 1'b1;
    assign tick    = (hc == half_m1);
    assign rx_word = rsh;

    // next state and FIFO strobes
    always_comb begin
        st_nx   = st;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        unique case (st)
            ST_IDLE: if (!tx_empty) begin
                tx_pop = 1'b1;
                st_nx  = ST_LEAD;
            end
            ST_LEAD, ST_LOW: if (tick) st_nx = ST_HIGH;
            ST_HIGH: if (tick) begin
                if (bits_left == 6'd1) begin
                    rx_push = 1'b1;
                    st_nx   = ST_TAIL;
                end else begin
                    st_nx = ST_LOW;
                end
            end
            ST_TAIL: if (tick) begin
                if (!tx_empty) begin
                    tx_pop = 1'b1;
                    st_nx  = ST_LEAD;
                end else begin
                    st_nx = ST_IDLE;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    // shift registers and half-period counter
    always_ff @(posedge clk) begin
        if (rst) begin
            hc        <= '0;
            bits_left <= '0;
            tsh       <= '0;
            rsh       <= '0;
            cs_q      <= '0;
        end else begin
            hc <= (st != st_nx || st == ST_IDLE) ? '0 : hc + 1'b1;
            if (tx_pop) begin
                tsh       <= tx_word << (6'd32 - fsz);
                bits_left <= fsz;
                rsh       <= '0;
                if (st == ST_IDLE) cs_q <= cs_sel;
            end
            if ((st == ST_LEAD || st == ST_LOW) && tick)
                rsh <= {rsh[WORD_W-2:0], miso};
            if (st == ST_HIGH && tick) begin
                bits_left <= bits_left - 6'd1;
                if (bits_left != 6'd1) tsh <= {tsh[WORD_W-2:0], 1'b0};
            end
        end
    end

    // pin outputs
    always_comb begin
        sclk = (st == ST_HIGH);
        mosi = (st == ST_IDLE) ? 1'b0 : tsh[WORD_W-1];
        cs_n = '1;
        if (st != ST_IDLE) cs_n[cs_q] = 1'b0;
    end

    a_r6_sclk_needs_select: assert property (@(posedge clk) disable iff (rst)
        (&cs_n) |-> !sclk);
    a_r5_mosi_steady_high: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));
    a_r2_push_ends_high: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> sclk);
    a_r12_pins_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mosi && (&cs_n) && !sclk));
endmodule

// File: rtl/spi_req_ctrl.sv
module spi_req_ctrl #(
    parameter int TXC = 4,
    parameter int RXC = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [TXC-1:0] tx_level,
    input  logic [RXC-1:0] rx_level,
    input  logic [TXC-1:0] tx_thresh,
    input  logic [RXC-1:0] rx_thresh,
    input  logic           ovf_evt,
    input  logic [2:0]     clr,
    input  logic [2:0]     irq_en,
    input  logic [1:0]     dma_en,
    output logic [2:0]     status,
    output logic           irq,
    output logic           dma_tx_req,
    output logic           dma_rx_req
);
    logic tx_low, rx_high;

    assign tx_low     = (tx_level <= tx_thresh);
    assign rx_high    = (rx_level != '0) && (rx_level >= rx_thresh);
    assign dma_tx_req = dma_en[0] && tx_low;
    assign dma_rx_req = dma_en[1] && rx_high;
    assign irq        = |(status & irq_en);

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr) | {ovf_evt, rx_high, tx_low};
    end

    a_r8_status_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & $past(status & ~clr)) == $past(status & ~clr)));
    a_r11_overrun_latches: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> status[2]);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spi_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    parameter int NCS      = 4,
    parameter int DIV_W    = 8,
    localparam int TXC     = $clog2(TX_DEPTH) + 1,
    localparam int RXC     = $clog2(RX_DEPTH) + 1,
    localparam int CSW     = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [WORD_W-1:0] host_rdata,
    output logic              tx_full,
    output logic              rx_empty,
    output logic [TXC-1:0]    tx_level,
    output logic [RXC-1:0]    rx_level,
    input  logic [5:0]        frame_bits,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [CSW-1:0]    cs_sel,
    input  logic [TXC-1:0]    tx_thresh,
    input  logic [RXC-1:0]    rx_thresh,
    input  logic [2:0]        irq_en,
    input  logic [1:0]        dma_en,
    input  logic [2:0]        status_clr,
    output logic [2:0]        status,
    output logic              irq,
    output logic              dma_tx_req,
    output logic              dma_rx_req,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NCS-1:0]    cs_n
);
    logic [5:0]        fsz;
    logic [WORD_W-1:0] fmask, tx_head, rx_word;
    logic              tx_pop, rx_push, rx_full;

    assign fsz      = (frame_bits < 6'd4) ? 6'd4 : (frame_bits > 6'd32) ? 6'd32 : frame_bits;
    assign fmask    = (fsz == 6'd32) ? '1 : ((WORD_W'(1) << fsz) - WORD_W'(1));
    assign tx_full  = (tx_level == TXC'(TX_DEPTH));
    assign rx_full  = (rx_level == RXC'(RX_DEPTH));
    assign rx_empty = (rx_level == '0);

    spi_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst),
        .push(host_wr), .pdata(host_wdata & fmask),
        .pop(tx_pop), .qdata(tx_head), .count(tx_level)
    );

    spi_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst),
        .push(rx_push), .pdata(rx_word),
        .pop(host_rd), .qdata(host_rdata), .count(rx_level)
    );

    spi_shift_engine #(.NCS(NCS), .DIV_W(DIV_W)) u_engine (
        .clk(clk), .rst(rst),
        .tx_empty(tx_level == '0), .tx_word(tx_head), .tx_pop(tx_pop),
        .fsz(fsz), .half_div(half_div), .cs_sel(cs_sel), .miso(miso),
        .rx_push(rx_push), .rx_word(rx_word),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );

    spi_req_ctrl #(.TXC(TXC), .RXC(RXC)) u_req (
        .clk(clk), .rst(rst),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
        .ovf_evt(rx_push && rx_full), .clr(status_clr),
        .irq_en(irq_en), .dma_en(dma_en),
        .status(status), .irq(irq),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
    );
endmodule

// File: tb/test_spi_fifo_master.sv
`timescale 1ns/1ps
module test_spi_fifo_master;
    logic        clk = 1'b0, rst = 1'b1;
    logic        host_wr = 0, host_rd = 0;
    logic [31:0] host_wdata = 0, host_rdata;
    logic        tx_full, rx_empty;
    logic [3:0]  tx_level, rx_level, tx_thresh = 0, rx_thresh = 1;
    logic [5:0]  frame_bits = 8;
    logic [7:0]  half_div = 1;
    logic [1:0]  cs_sel = 0;
    logic [2:0]  irq_en = 0, status_clr = 0, status;
    logic [1:0]  dma_en = 0;
    logic        irq, dma_tx_req, dma_rx_req, sclk, mosi, miso;
    logic [3:0]  cs_n;
    logic        inv = 0;

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    assign miso = mosi ^ inv;
    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_fifo_master i_spi_fifo_master (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .tx_full(tx_full),
        .rx_empty(rx_empty), .tx_level(tx_level), .rx_level(rx_level),
        .frame_bits(frame_bits), .half_div(half_div), .cs_sel(cs_sel),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .irq_en(irq_en),
        .dma_en(dma_en), .status_clr(status_clr), .status(status), .irq(irq),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // bench model helpers
    function automatic int eff_f(input int f);
        return (f < 4) ? 4 : (f > 32) ? 32 : f;
    endfunction
    function automatic logic [31:0] mask_f(input int f);
        return (f == 32) ? 32'hFFFF_FFFF : ((32'd1 << f) - 32'd1);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // line monitor
    int cur_f = 8, cur_hd = 1, cur_sel = 0;
    int mon_n = 0, mon_frames = 0, per_err = 0, tim_err = 0, sel_err = 0, cs_rises = 0;
    int last_rise = 0, last_fall = 0, cs_fall = 0;
    bit first_rise = 0, sclk_d = 0, csall_d = 1;
    logic [31:0] mon_word = 0;
    logic [31:0] mon_q [16];

    always @(negedge clk) begin
        if (!rst) begin
            if (!(&cs_n) && csall_d) begin cs_fall = cyc; first_rise = 1; end
            if ((&cs_n) && !csall_d) begin
                cs_rises++;
                if (cyc - last_fall != cur_hd) tim_err++;
            end
            if (!(&cs_n) && cs_n != ~(4'b1 << cur_sel)) sel_err++;
            if (sclk && !sclk_d) begin
                if (first_rise) begin
                    if (cyc - cs_fall != cur_hd) tim_err++;
                    first_rise = 0;
                end
                if (mon_n > 0 && cyc - last_rise != 2 * cur_hd) per_err++;
                last_rise = cyc;
                mon_word = {mon_word[30:0], mosi};
                mon_n++;
                if (mon_n == cur_f) begin
                    if (mon_frames < 16) mon_q[mon_frames] = mon_word & mask_f(cur_f);
                    mon_frames++;
                    mon_n = 0;
                end
            end
            if (!sclk && sclk_d) last_fall = cyc;
            sclk_d  = sclk;
            csall_d = &cs_n;
        end
    end

    // host drivers, entered and left at a falling edge
    task automatic push_word(input logic [31:0] w);
        host_wr = 1; host_wdata = w;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic pop_chk(input logic [31:0] exp, input string req);
        check(host_rdata == exp, req, "rx word", host_rdata, exp);
        host_rd = 1;
        @(negedge clk);
        host_rd = 0;
    endtask

    task automatic clr_pulse(input logic [2:0] m);
        status_clr = m;
        @(negedge clk);
        status_clr = 0;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (!(tx_level == 0 && (&cs_n))) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic arm(input int f, input int hd, input int sel, input bit iv);
        frame_bits = f[5:0]; half_div = hd[7:0]; cs_sel = sel[1:0]; inv = iv;
        cur_f = eff_f(f); cur_hd = (hd == 0) ? 1 : hd; cur_sel = sel;
        mon_n = 0; mon_frames = 0; per_err = 0; tim_err = 0; sel_err = 0; cs_rises = 0;
    endtask

    task automatic run_burst(input int n, input int f, input int hd, input int sel, input bit iv);
        logic [31:0] w [16];
        logic [31:0] m;
        arm(f, hd, sel, iv);
        m = mask_f(eff_f(f));
        for (int i = 0; i < n; i++) begin
            w[i] = $urandom;
            push_word(w[i]);
        end
        wait_idle();
        check(mon_frames == n, "R2", "frames sent", mon_frames, n);
        check(rx_level == n[3:0], "R2", "rx entries", {28'b0, rx_level}, n);
        check(per_err == 0, "R1", "sclk period", per_err, 0);
        check(tim_err == 0, "R7", "select lead/tail", tim_err, 0);
        check(sel_err == 0, "R6", "select line", sel_err, 0);
        check(cs_rises == 1, "R6", "one select per burst", cs_rises, 1);
        for (int i = 0; i < n; i++)
            check(mon_q[i] == (w[i] & m), "R4", "mosi bits", mon_q[i], w[i] & m);
        for (int i = 0; i < n; i++)
            pop_chk((w[i] & m) ^ (iv ? m : 32'h0), "R5");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R12 during reset
        check(mosi == 0 && (&cs_n) && !sclk, "R12", "pins in reset", {mosi, sclk, cs_n}, 6'b001111);
        check(status == 0 && rx_empty && tx_level == 0, "R12", "state in reset", {status, rx_level}, 0);
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(mosi == 0 && (&cs_n), "R12", "pins after reset", {mosi, cs_n}, 5'b01111);

        // directed boundaries and clamp
        run_burst(3, 4, 1, 0, 0);
        run_burst(2, 32, 2, 3, 1);
        run_burst(2, 2, 0, 1, 0);     // R4 clamp low, R1 half_div 0 acts as 1
        run_burst(1, 40, 3, 2, 1);    // R4 clamp high
        // constrained random bursts
        for (int r = 0; r < 8; r++)
            run_burst(1 + $urandom_range(0, 5), $urandom_range(4, 32),
                      $urandom_range(1, 4), $urandom_range(0, 3), $urandom_range(0, 1));

        // R8 R9 R10 receive threshold
        irq_en = 3'b010; rx_thresh = 2; dma_en = 2'b10;
        clr_pulse(3'b111);
        arm(8, 1, 0, 0);
        push_word(32'hA5); wait_idle();
        check(!irq && !dma_rx_req, "R8", "below rx threshold", {irq, dma_rx_req}, 0);
        push_word(32'h3C); wait_idle();
        check(irq == 1, "R9", "irq at rx threshold", irq, 1);
        check(dma_rx_req == 1, "R10", "dma rx at threshold", dma_rx_req, 1);
        clr_pulse(3'b010);
        check(irq == 1, "R8", "clear while condition holds", irq, 1);
        pop_chk(32'hA5, "R5");
        @(negedge clk);
        check(irq == 1 && !dma_rx_req, "R8", "sticky after drain", {irq, dma_rx_req}, 2'b10);
        clr_pulse(3'b010);
        check(irq == 0, "R8", "clear after drain", irq, 0);
        pop_chk(32'h3C, "R5");

        // R3 full write ignored, R11 overrun, R10 tx request
        irq_en = 3'b100; dma_en = 2'b01; tx_thresh = 2;
        arm(4, 20, 1, 0);
        for (int i = 0; i < 10; i++) push_word(32'h10 + i);
        check(tx_level == 8 && tx_full, "R3", "write to full fifo", tx_level, 8);
        check(dma_tx_req == 0, "R10", "tx above threshold", dma_tx_req, 0);
        wait_idle();
        check(dma_tx_req == 1, "R10", "tx at threshold", dma_tx_req, 1);
        check(mon_frames == 9, "R3", "accepted words", mon_frames, 9);
        check(status[2] && irq, "R11", "overrun flag", {status[2], irq}, 2'b11);
        for (int i = 0; i < 8; i++) pop_chk((32'h10 + i) & 32'hF, "R11");
        check(rx_empty == 1, "R11", "dropped frame absent", rx_level, 0);
        check(status[2] == 1, "R11", "overrun sticky", status[2], 1);
        clr_pulse(3'b100);
        check(status[2] == 0 && !irq, "R11", "overrun cleared", {status[2], irq}, 0);

        // R3 read of empty fifo ignored
        host_rd = 1; @(negedge clk); host_rd = 0;
        check(rx_level == 0, "R3", "read of empty fifo", rx_level, 0);
        run_burst(1, 12, 1, 0, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule